// File: doc/BRIEF.md
# Thread-Aware Register Rename Table

This block renames architectural registers for a core that runs two or four hardware threads at once. Each thread has its own architectural register space. All threads draw physical registers from one shared physical register file. A table entry is selected by joining the thread number, as the upper bits, to the architectural register number. Each cycle the table answers two source lookups. It can also install one new destination mapping, taking the new physical tag from the head of a shared free-tag FIFO and reporting the mapping it replaces.

Next to the speculative table sits a committed table with one copy per thread. A retiring instruction writes its mapping into the committed table, and the physical tag it displaced goes back to the tail of the free FIFO. A flush for one thread copies that thread's committed entries over its speculative entries in a single cycle. The other threads are not touched. Tags leave the rename stage unique across threads, so later stages need no knowledge of threads.

A small controller has two states. Reset enters `ST_FILL`. In that state the free FIFO is loaded with one tag per cycle and every rename request is stalled. Once the last tag is loaded, the controller moves to `ST_RUN` and stays there until the next reset.

Top module: `thread_rat`

## Requirements
- R1: An entry is selected by the index {thread, arch register}. The same register number in two threads resolves to two different physical tags, and a rename in one thread leaves the other thread's lookups unchanged.
- R2: After reset, both tables map thread t, register r to tag t*ARCH_REGS+r. The controller stays in `ST_FILL` for exactly DEPTH = PHYS_REGS-THREADS*ARCH_REGS cycles. In that time it loads tags THREADS*ARCH_REGS through PHYS_REGS-1 into the free FIFO in ascending order. While `ready` is low, every valid rename raises `ren_stall`.
- R3: `src0_ptag` and `src1_ptag` are read from the speculative table in the same cycle. A source that names the destination being renamed in that cycle returns the mapping held before the write.
- R4: A destination rename that is not stalled presents the free FIFO head on `dst_ptag` and the replaced mapping on `dst_old_ptag`. The table holds `dst_ptag` for that register from the next cycle on.
- R5: When the free FIFO is empty, a rename with a destination raises `ren_stall`. No mapping changes and no tag is consumed.
- R6: A commit writes `cmt_new_ptag` into the thread's committed entry and appends `cmt_old_ptag` to the tail of the free FIFO. Freed tags are handed out again in FIFO order, and the FIFO never overflows.
- R7: A flush of thread t copies all of thread t's committed entries into its speculative entries in one cycle, and the other threads keep their speculative entries. A commit in the same cycle is included in the copied values.
- R8: A rename in the same cycle as a flush of its own thread is stalled. A rename from another thread in that cycle proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request valid |
| ren_tid | input | TID_W | Thread of the rename request |
| src0_areg | input | AREG_W | First source architectural register |
| src1_areg | input | AREG_W | Second source architectural register |
| dst_valid | input | 1 | Request has a destination |
| dst_areg | input | AREG_W | Destination architectural register |
| src0_ptag | output | PTAG_W | Physical tag of first source |
| src1_ptag | output | PTAG_W | Physical tag of second source |
| dst_ptag | output | PTAG_W | New physical tag for the destination |
| dst_old_ptag | output | PTAG_W | Tag previously mapped to the destination |
| ren_stall | output | 1 | Rename not accepted this cycle |
| ready | output | 1 | Free FIFO loaded, table in service |
| cmt_valid | input | 1 | Commit valid |
| cmt_tid | input | TID_W | Thread of the committing instruction |
| cmt_areg | input | AREG_W | Committed architectural register |
| cmt_new_ptag | input | PTAG_W | Tag that becomes architected |
| cmt_old_ptag | input | PTAG_W | Tag returned to the free FIFO |
| flush_valid | input | 1 | Flush request |
| flush_tid | input | TID_W | Thread to restore |

## Verification
The bench renames the same register number in both threads. A design that drops the thread bits from the index would let one thread overwrite the other's mapping. It reads a source that names the destination being renamed in the same cycle; a table with a write-through path would return the new tag there. It issues a commit and a flush together, renames a thread while that same thread is flushed, and drains the free FIFO to empty. Here a wrong design would restore a stale committed value, corrupt the thread it is restoring, or hand out a tag it does not have. Finally it frees a tag after the drain and expects that exact tag on the next rename, which catches a FIFO that loses or reorders its returns.

// File: rtl/thread_rat_pkg.sv
package thread_rat_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } rat_state_e;
endpackage

// File: rtl/rat_fill_ctrl.sv
module rat_fill_ctrl
    import thread_rat_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int BASE   = 32,
    parameter int PTAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    output logic              fill_push,
    output logic [PTAG_W-1:0] fill_tag
);
    localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rat_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (cnt_q == CNT_W'(DEPTH - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // state register and load counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        fill_push = 1'b0;
        fill_tag  = PTAG_W'(BASE) + PTAG_W'(cnt_q);
        unique case (state_q)
            ST_FILL: fill_push = 1'b1;
            ST_RUN:  ready     = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rat_free_fifo.sv
module rat_free_fifo #(
    parameter int DEPTH  = 32,
    parameter int PTAG_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [PTAG_W-1:0]          push_tag,
    input  logic                       pop,
    output logic [PTAG_W-1:0]          head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PTAG_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rd_q, wr_q;
    logic [CW-1:0]     cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= push_tag;
                wr_q      <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;
endmodule

// File: rtl/rat_map_table.sv
module rat_map_table #(
    parameter int THREADS = 2,
    parameter int TID_W   = 1,
    parameter int AREG_W  = 4,
    parameter int PTAG_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TID_W+AREG_W-1:0]   rd0_idx,
    input  logic [TID_W+AREG_W-1:0]   rd1_idx,
    input  logic [TID_W+AREG_W-1:0]   wr_idx,
    output logic [PTAG_W-1:0]         rd0_tag,
    output logic [PTAG_W-1:0]         rd1_tag,
    output logic [PTAG_W-1:0]         wr_old_tag,
    input  logic                      wr_en,
    input  logic [PTAG_W-1:0]         wr_tag,
    input  logic                      cmt_en,
    input  logic [TID_W+AREG_W-1:0]   cmt_idx,
    input  logic [PTAG_W-1:0]         cmt_tag,
    input  logic                      flush_en,
    input  logic [TID_W-1:0]          flush_tid
);
    localparam int IDX_W   = TID_W + AREG_W;
    localparam int ENTRIES = THREADS << AREG_W;

    logic [PTAG_W-1:0] spec_q [ENTRIES];
    logic [PTAG_W-1:0] arch_q [ENTRIES];
    logic [PTAG_W-1:0] arch_d [ENTRIES];

    // committed view including this cycle's commit, used by the flush copy
    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            arch_d[i] = (cmt_en && cmt_idx == IDX_W'(i)) ? cmt_tag : arch_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                spec_q[i] <= PTAG_W'(i);
                arch_q[i] <= PTAG_W'(i);
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                arch_q[i] <= arch_d[i];
                if (flush_en && TID_W'(i >> AREG_W) == flush_tid)
                    spec_q[i] <= arch_d[i];
                else if (wr_en && wr_idx == IDX_W'(i))
                    spec_q[i] <= wr_tag;
            end
        end
    end

    assign rd0_tag    = spec_q[rd0_idx];
    assign rd1_tag    = spec_q[rd1_idx];
    assign wr_old_tag = spec_q[wr_idx];
endmodule

// File: rtl/thread_rat.sv
module thread_rat #(
    parameter int THREADS   = 2,
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 64,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int AREG_W = $clog2(ARCH_REGS),
    localparam int PTAG_W = $clog2(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [TID_W-1:0]  ren_tid,
    input  logic [AREG_W-1:0] src0_areg,
    input  logic [AREG_W-1:0] src1_areg,
    input  logic              dst_valid,
    input  logic [AREG_W-1:0] dst_areg,
    output logic [PTAG_W-1:0] src0_ptag,
    output logic [PTAG_W-1:0] src1_ptag,
    output logic [PTAG_W-1:0] dst_ptag,
    output logic [PTAG_W-1:0] dst_old_ptag,
    output logic              ren_stall,
    output logic              ready,
    input  logic              cmt_valid,
    input  logic [TID_W-1:0]  cmt_tid,
    input  logic [AREG_W-1:0] cmt_areg,
    input  logic [PTAG_W-1:0] cmt_new_ptag,
    input  logic [PTAG_W-1:0] cmt_old_ptag,
    input  logic              flush_valid,
    input  logic [TID_W-1:0]  flush_tid
);
    localparam int DEPTH = PHYS_REGS - THREADS * ARCH_REGS;
    localparam int BASE  = THREADS * ARCH_REGS;
    localparam int CW    = $clog2(DEPTH + 1);

    logic              fill_push;
    logic [PTAG_W-1:0] fill_tag;
    logic              fl_push, fl_pop, fl_empty, fl_full;
    logic [PTAG_W-1:0] fl_head, fl_push_tag;
    logic [CW-1:0]     fl_count;
    logic              ren_we, cmt_we;

    rat_fill_ctrl #(.DEPTH(DEPTH), .BASE(BASE), .PTAG_W(PTAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .fill_push(fill_push), .fill_tag(fill_tag)
    );

    assign ren_stall = ren_valid &&
                       (!ready || (dst_valid && fl_empty) ||
                        (flush_valid && flush_tid == ren_tid));
    assign ren_we    = ren_valid && dst_valid && !ren_stall;
    assign cmt_we    = cmt_valid && ready;

    assign fl_pop      = ren_we;
    assign fl_push     = fill_push || cmt_we;
    assign fl_push_tag = fill_push ? fill_tag : cmt_old_ptag;

    rat_free_fifo #(.DEPTH(DEPTH), .PTAG_W(PTAG_W)) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(fl_push), .push_tag(fl_push_tag), .pop(fl_pop),
        .head(fl_head), .empty(fl_empty), .full(fl_full), .count(fl_count)
    );

    rat_map_table #(.THREADS(THREADS), .TID_W(TID_W), .AREG_W(AREG_W), .PTAG_W(PTAG_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx({ren_tid, src0_areg}), .rd1_idx({ren_tid, src1_areg}),
        .wr_idx({ren_tid, dst_areg}),
        .rd0_tag(src0_ptag), .rd1_tag(src1_ptag), .wr_old_tag(dst_old_ptag),
        .wr_en(ren_we), .wr_tag(fl_head),
        .cmt_en(cmt_we), .cmt_idx({cmt_tid, cmt_areg}), .cmt_tag(cmt_new_ptag),
        .flush_en(flush_valid), .flush_tid(flush_tid)
    );

    assign dst_ptag = fl_head;
endmodule

// File: rtl/thread_rat_chk.sv
module thread_rat_chk #(
    parameter int DEPTH  = 32,
    parameter int TID_W  = 1,
    parameter int PTAG_W = 6,
    parameter int CW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ren_valid,
    input logic              dst_valid,
    input logic [TID_W-1:0]  ren_tid,
    input logic              flush_valid,
    input logic [TID_W-1:0]  flush_tid,
    input logic              ren_stall,
    input logic              ready,
    input logic              ren_we,
    input logic              fl_push,
    input logic              fl_pop,
    input logic              fl_full,
    input logic [CW-1:0]     fl_count,
    input logic [PTAG_W-1:0] dst_ptag,
    input logic [PTAG_W-1:0] dst_old_ptag
);
    AST_NOT_READY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && !ready |-> ren_stall); // R2
    AST_FILL_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> fl_count == CW'(DEPTH)); // R2
    AST_NEW_TAG_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ren_we |-> dst_ptag != dst_old_ptag); // R4
    AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ren_we && !fl_push |=> fl_count == $past(fl_count) - 1'b1); // R4
    AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && dst_valid && fl_count == '0 |-> ren_stall); // R5
    AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> !fl_pop); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fl_push && !fl_pop |-> !fl_full); // R6
    AST_FLUSH_BLOCKS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && flush_valid && ren_tid == flush_tid |-> !ren_we); // R8
endmodule

bind thread_rat thread_rat_chk #(
    .DEPTH(DEPTH), .TID_W(TID_W), .PTAG_W(PTAG_W), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .dst_valid(dst_valid),
    .ren_tid(ren_tid), .flush_valid(flush_valid), .flush_tid(flush_tid),
    .ren_stall(ren_stall), .ready(ready), .ren_we(ren_we),
    .fl_push(fl_push), .fl_pop(fl_pop), .fl_full(fl_full), .fl_count(fl_count),
    .dst_ptag(dst_ptag), .dst_old_ptag(dst_old_ptag)
);

// File: tb/thread_rat_bench.sv
module thread_rat_bench;
    localparam int T = 2, A = 16, P = 64;
    localparam int DEPTH = P - T * A;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       ren_valid = 0, dst_valid = 0, cmt_valid = 0, flush_valid = 0;
    logic [0:0] ren_tid = 0, cmt_tid = 0, flush_tid = 0;
    logic [3:0] src0_areg = 0, src1_areg = 0, dst_areg = 0, cmt_areg = 0;
    logic [5:0] cmt_new_ptag = 0, cmt_old_ptag = 0;
    logic [5:0] src0_ptag, src1_ptag, dst_ptag, dst_old_ptag;
    logic       ren_stall, ready;

    int checks = 0, errors = 0;
    int m_spec [T*A];
    int m_arch [T*A];
    int q [$];

    always #10 clk = ~clk;

    thread_rat #(.THREADS(T), .ARCH_REGS(A), .PHYS_REGS(P)) u_thread_rat (.*);

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // one cycle of stimulus, checked against the bench model
    task automatic cyc(input string req,
                       input bit rv, input int rt, input int s0, input int s1,
                       input bit dv, input int d,
                       input bit cv, input int ct, input int ca, input int cn, input int co,
                       input bit fv, input int ft);
        bit exp_stall, we;
        int didx;
        @(negedge clk);
        ren_valid = rv; ren_tid = rt[0]; src0_areg = s0[3:0]; src1_areg = s1[3:0];
        dst_valid = dv; dst_areg = d[3:0];
        cmt_valid = cv; cmt_tid = ct[0]; cmt_areg = ca[3:0];
        cmt_new_ptag = cn[5:0]; cmt_old_ptag = co[5:0];
        flush_valid = fv; flush_tid = ft[0];
        #2;
        didx = rt * A + d;
        exp_stall = rv && ((dv && q.size() == 0) || (fv && ft == rt));
        we = rv && dv && !exp_stall;
        if (rv) begin
            chk({req, " stall"}, ren_stall, exp_stall);
            chk({req, " src0"}, src0_ptag, m_spec[rt*A+s0]);
            chk({req, " src1"}, src1_ptag, m_spec[rt*A+s1]);
        end
        if (we) begin
            chk({req, " dst"}, dst_ptag, q[0]);
            chk({req, " old"}, dst_old_ptag, m_spec[didx]);
        end
        @(posedge clk);
        if (cv) begin
            m_arch[ct*A+ca] = cn;
            q.push_back(co);
        end
        if (we) m_spec[didx] = q.pop_front();
        if (fv) for (int r = 0; r < A; r++) m_spec[ft*A+r] = m_arch[ft*A+r];
        #1;
        ren_valid = 0; dst_valid = 0; cmt_valid = 0; flush_valid = 0;
    endtask

    task automatic look(input string req, input int t, input int r);
        cyc(req, 1, t, r, r, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset;
        int n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        ren_valid = 1; dst_valid = 1;
        #2;
        chk("R2 stall while loading", ren_stall, 1);
        chk("R2 ready low", ready, 0);
        while (!ready && n < 200) begin
            @(posedge clk); #1; n++;
        end
        ren_valid = 0; dst_valid = 0;
        chk("R2 load cycles", n, DEPTH);
        for (int i = 0; i < T*A; i++) begin
            m_spec[i] = i; m_arch[i] = i;
        end
        for (int i = T*A; i < P; i++) q.push_back(i);
        for (int r = 0; r < A; r++) begin
            look("R2 identity t0", 0, r);
            look("R2 identity t1", 1, r);
        end
    endtask

    task automatic t_rename;
        cyc("R3 R4 rename t0 r3", 1, 0, 3, 3, 1, 3, 0, 0, 0, 0, 0, 0, 0);
        look("R1 t0 r3 after", 0, 3);
        look("R1 t1 r3 untouched", 1, 3);
        chk("R4 t0 r3 tag", m_spec[3], 32);
    endtask

    task automatic t_commit_flush;
        cyc("R4 rename t0 r3 again", 1, 0, 3, 5, 1, 3, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1 rename t1 r4", 1, 1, 4, 3, 1, 4, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6 commit t0 r3", 0, 0, 0, 0, 0, 0, 1, 0, 3, 32, 3, 0, 0);
        cyc("R7 flush t0", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        look("R7 t0 r3 restored", 0, 3);
        look("R7 t1 r4 kept", 1, 4);
    endtask

    task automatic t_flush_with_commit;
        int nt;
        cyc("R4 rename t0 r7", 1, 0, 7, 7, 1, 7, 0, 0, 0, 0, 0, 0, 0);
        nt = m_spec[7];
        cyc("R7 commit+flush t0", 0, 0, 0, 0, 0, 0, 1, 0, 7, nt, 7, 1, 0);
        look("R7 t0 r7 has committed tag", 0, 7);
    endtask

    task automatic t_flush_conflict;
        cyc("R8 rename t1 during own flush", 1, 1, 4, 9, 1, 9, 0, 0, 0, 0, 0, 1, 1);
        look("R8 t1 r9 unchanged", 1, 9);
        look("R8 t1 r4 restored", 1, 4);
        cyc("R8 rename t1 during t0 flush", 1, 1, 9, 2, 1, 9, 0, 0, 0, 0, 0, 1, 0);
        look("R8 t1 r9 renamed", 1, 9);
    endtask

    task automatic t_empty;
        int k = 0;
        int old;
        while (q.size() > 0 && k < 100) begin
            cyc("R4 drain", 1, 0, k % A, (k + 1) % A, 1, 10 + (k % 4), 0, 0, 0, 0, 0, 0, 0);
            k++;
        end
        cyc("R5 rename on empty", 1, 0, 10, 11, 1, 12, 0, 0, 0, 0, 0, 0, 0);
        look("R5 t0 r12 unchanged", 0, 12);
        old = m_arch[9];
        cyc("R6 commit t0 r9", 0, 0, 0, 0, 0, 0, 1, 0, 9, m_spec[9], old, 0, 0);
        cyc("R6 reuse freed tag", 1, 1, 0, 1, 1, 6, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 freed tag reissued", m_spec[A+6], old);
        look("R6 t1 r6 mapping", 1, 6);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_rename();
        t_commit_flush();
        t_flush_with_commit();
        t_flush_conflict();
        t_empty();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule